// File: doc/BRIEF.md
# Next-PC and Branch Target Unit

This block holds the program counter of a processor whose instructions are all 32 bits long. Each cycle it picks the next fetch address. The choice depends on the current PC, the instruction fetched at that PC, a register-equality flag and the contents of one source register. The choice takes effect at the next clock edge if the advance enable is high.

The block handles five cases:
- sequential flow;
- the two conditional branches, taken on equal or on not-equal;
- the absolute jump;
- jump-and-link;
- jump-through-register.

For jump-and-link it also drives a write request, a destination register number and a data value so that the register file can capture the return address. The unit decodes only the instruction fields it needs. Operand fetch, the comparison itself and all other datapath work stay outside.

Top module: `npc_unit`

## Requirements
- R1: While `rst_ni` is low the PC is 0x00000000, and `link_we_o` is 0.
- R2: When `en_i` is low at a rising clock edge, the PC keeps its value, whatever the instruction.
- R3: An instruction whose opcode (bits 31:26) is not 000000, 000010, 000011, 000100 or 000101 moves the PC to PC+4. The sum is taken modulo 2^32, so 0xFFFFFFFC advances to 0x00000000.
- R4: Opcode 000100 is a branch-on-equal. When `regs_eq_i` is 1, the next PC is PC+4 plus four times the sign-extended 16-bit offset in bits 15:0. When `regs_eq_i` is 0, the next PC is PC+4.
- R5: Opcode 000101 is a branch-on-not-equal. It uses the same target as R4 and is taken when `regs_eq_i` is 0; otherwise the next PC is PC+4.
- R6: Opcode 000010 is a jump. The next PC is made of bits 31:28 of PC+4, then the 26-bit field in bits 25:0, then two zero bits.
- R7: Opcode 000011 is jump-and-link. It uses the jump target of R6. In the same cycle, and only while `en_i` is high, it drives `link_we_o`=1, `link_addr_o`=31 and `link_data_o`=PC+4. No other instruction raises `link_we_o`.
- R8: Opcode 000000 with function code 001000 in bits 5:0 is a jump-register. When bits 1:0 of `rs_val_i` are 00, the next PC is `rs_val_i`.
- R9: A jump-register whose `rs_val_i` has nonzero bits 1:0 drives `misalign_o`=1 in that cycle, and the PC advances to PC+4. `misalign_o` is 0 for every other case.
- R10: Opcode 000000 with any function code other than 001000 is sequential, as in R3.
- R11: Branch offsets reach the full range from -32768 to +32767 instructions. The target arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance enable for the PC |
| instr_i | input | 32 | Instruction fetched at the current PC |
| rs_val_i | input | 32 | Contents of the first source register |
| regs_eq_i | input | 1 | High when the two source registers are equal |
| pc_o | output | 32 | Current program counter |
| link_we_o | output | 1 | Write request for the return address |
| link_addr_o | output | 5 | Destination register number of the link write |
| link_data_o | output | 32 | Return address, PC+4 |
| misalign_o | output | 1 | Jump-register target not word aligned |

## Verification
The checker watches, on every cycle, the properties that need no target arithmetic:
- the PC holds while the enable is low;
- the PC stays word aligned;
- non-control opcodes and misaligned jump-register targets advance by four;
- aligned jump-register targets load the register value;
- the link write appears only with the jump-and-link opcode and carries PC+4 to register 31.

Some behaviour shows only in the bench's instruction sequences:
- correct sign extension and scaling of branch offsets at both ends of their range;
- the taken and not-taken choice of both branch kinds;
- the reuse of the upper PC bits in absolute jumps after the PC has been moved into a high region;
- wrap-around at the top of the address space.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int XLEN     = 32;
  localparam int OP_W     = 6;
  localparam int FN_W     = 6;
  localparam int OFF_W    = 16;
  localparam int TGT_W    = 26;
  localparam int REG_W    = 5;
  localparam int LINK_REG = 31;
  localparam int INSTR_B  = 4;

  localparam logic [OP_W-1:0] OP_SPECIAL = 6'b000000;
  localparam logic [OP_W-1:0] OP_JMP     = 6'b000010;
  localparam logic [OP_W-1:0] OP_JAL     = 6'b000011;
  localparam logic [OP_W-1:0] OP_BEQ     = 6'b000100;
  localparam logic [OP_W-1:0] OP_BNE     = 6'b000101;
  localparam logic [FN_W-1:0] FN_JR      = 6'b001000;

  typedef enum logic [2:0] {
    FLOW_SEQ,
    FLOW_BEQ,
    FLOW_BNE,
    FLOW_JMP,
    FLOW_JAL,
    FLOW_JR
  } flow_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [XLEN-1:0]  instr_i,
  output flow_e            flow_o,
  output logic [OFF_W-1:0] off_o,
  output logic [TGT_W-1:0] tgt_o
);
  logic [OP_W-1:0] op;
  logic [FN_W-1:0] fn;

  assign op    = instr_i[XLEN-1 -: OP_W];
  assign fn    = instr_i[FN_W-1:0];
  assign off_o = instr_i[OFF_W-1:0];
  assign tgt_o = instr_i[TGT_W-1:0];

  always_comb begin
    unique case (op)
      OP_BEQ:     flow_o = FLOW_BEQ;
      OP_BNE:     flow_o = FLOW_BNE;
      OP_JMP:     flow_o = FLOW_JMP;
      OP_JAL:     flow_o = FLOW_JAL;
      OP_SPECIAL: flow_o = (fn == FN_JR) ? FLOW_JR : FLOW_SEQ;
      default:    flow_o = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
(
  input  logic [XLEN-1:0]  pc_i,
  input  flow_e            flow_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [TGT_W-1:0] tgt_i,
  input  logic [XLEN-1:0]  rs_val_i,
  input  logic             regs_eq_i,
  output logic [XLEN-1:0]  npc_o,
  output logic [XLEN-1:0]  seq_o,
  output logic             misalign_o
);
  localparam int ALIGN_W = $clog2(INSTR_B);
  localparam int SEXT_W  = XLEN - OFF_W - ALIGN_W;
  localparam int HI_W    = XLEN - TGT_W - ALIGN_W;

  logic [XLEN-1:0] seq_pc, br_pc, jmp_pc;
  logic            take_br;

  assign seq_pc = pc_i + XLEN'(INSTR_B);
  // offset counts instructions from the following instruction
  assign br_pc  = seq_pc + {{SEXT_W{off_i[OFF_W-1]}}, off_i, {ALIGN_W{1'b0}}};
  assign jmp_pc = {seq_pc[XLEN-1 -: HI_W], tgt_i, {ALIGN_W{1'b0}}};

  assign take_br    = (flow_i == FLOW_BEQ &&  regs_eq_i) ||
                      (flow_i == FLOW_BNE && !regs_eq_i);
  assign misalign_o = (flow_i == FLOW_JR) && (rs_val_i[ALIGN_W-1:0] != '0);

  always_comb begin
    npc_o = seq_pc;
    if (take_br)                                      npc_o = br_pc;
    else if (flow_i == FLOW_JMP || flow_i == FLOW_JAL) npc_o = jmp_pc;
    else if (flow_i == FLOW_JR && !misalign_o)         npc_o = rs_val_i;
  end

  assign seq_o = seq_pc;
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [31:0]      instr_i,
  input  logic [31:0]      rs_val_i,
  input  logic             regs_eq_i,
  output logic [31:0]      pc_o,
  output logic             link_we_o,
  output logic [4:0]       link_addr_o,
  output logic [31:0]      link_data_o,
  output logic             misalign_o
);
  flow_e            flow;
  logic [OFF_W-1:0] off;
  logic [TGT_W-1:0] tgt;
  logic [XLEN-1:0]  pc_q, npc, seq;

  npc_decode u_dec (
    .instr_i (instr_i),
    .flow_o  (flow),
    .off_o   (off),
    .tgt_o   (tgt)
  );

  npc_target u_tgt (
    .pc_i       (pc_q),
    .flow_i     (flow),
    .off_i      (off),
    .tgt_i      (tgt),
    .rs_val_i   (rs_val_i),
    .regs_eq_i  (regs_eq_i),
    .npc_o      (npc),
    .seq_o      (seq),
    .misalign_o (misalign_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pc_q <= '0;
    else if (en_i) pc_q <= npc;
  end

  assign pc_o        = pc_q;
  assign link_we_o   = rst_ni && en_i && (flow == FLOW_JAL);
  assign link_addr_o = REG_W'(LINK_REG);
  assign link_data_o = seq;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en_i,
  input logic [5:0]  op_i,
  input logic [5:0]  fn_i,
  input logic [31:0] rs_val_i,
  input logic [31:0] pc_o,
  input logic        link_we_o,
  input logic [4:0]  link_addr_o,
  input logic [31:0] link_data_o,
  input logic        misalign_o
);
  logic is_ctl, is_jr;
  assign is_ctl = (op_i == 6'd0) || (op_i == 6'd2) || (op_i == 6'd3) ||
                  (op_i == 6'd4) || (op_i == 6'd5);
  assign is_jr  = (op_i == 6'd0) && (fn_i == 6'b001000);

  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(pc_o)); // R2
  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !is_ctl) |=> pc_o == $past(pc_o) + 32'd4); // R3
  AST_PC_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_o[1:0] == 2'b00); // R8
  AST_JR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && is_jr && rs_val_i[1:0] == 2'b00) |=> pc_o == $past(rs_val_i)); // R8
  AST_JR_MISALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && misalign_o) |=> pc_o == $past(pc_o) + 32'd4); // R9
  AST_MISALIGN_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> is_jr); // R9
  AST_LINK_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> (op_i == 6'b000011 && en_i)); // R7
  AST_LINK_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> (link_addr_o == 5'd31 && link_data_o == pc_o + 32'd4)); // R7
endmodule

bind npc_unit npc_unit_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .op_i        (instr_i[31:26]),
  .fn_i        (instr_i[5:0]),
  .rs_val_i    (rs_val_i),
  .pc_o        (pc_o),
  .link_we_o   (link_we_o),
  .link_addr_o (link_addr_o),
  .link_data_o (link_data_o),
  .misalign_o  (misalign_o)
);

// File: tb/npc_unit_tb.sv
`timescale 1ns/1ps
module npc_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] rs_val_i = '0;
  logic        regs_eq_i = 1'b0;
  logic [31:0] pc_o, link_data_o;
  logic [4:0]  link_addr_o;
  logic        link_we_o, misalign_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [31:0] pc_ref = '0;

  always #2 clk_i = ~clk_i;

  npc_unit dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .instr_i     (instr_i),
    .rs_val_i    (rs_val_i),
    .regs_eq_i   (regs_eq_i),
    .pc_o        (pc_o),
    .link_we_o   (link_we_o),
    .link_addr_o (link_addr_o),
    .link_data_o (link_data_o),
    .misalign_o  (misalign_o)
  );

  // {instr, rs_val, eq, en}
  localparam int NV = 18;
  localparam logic [65:0] VECS [NV] = '{
    {32'h20080004, 32'h0,        1'b0, 1'b1},
    {32'h00851020, 32'h0,        1'b0, 1'b1},
    {32'h10200003, 32'h0,        1'b1, 1'b1},
    {32'h10200003, 32'h0,        1'b0, 1'b1},
    {32'h1400FFFE, 32'h0,        1'b0, 1'b1},
    {32'h1400FFFE, 32'h0,        1'b1, 1'b1},
    {32'h08000100, 32'h0,        1'b0, 1'b0},
    {32'h08000100, 32'h0,        1'b0, 1'b1},
    {32'h0C000040, 32'h0,        1'b0, 1'b1},
    {32'h03E00008, 32'hF0000010, 1'b0, 1'b1},
    {32'h08000100, 32'h0,        1'b0, 1'b1},
    {32'h03E00008, 32'h00000203, 1'b0, 1'b1},
    {32'h03E00008, 32'h7FFFFFFC, 1'b0, 1'b1},
    {32'h10007FFF, 32'h0,        1'b1, 1'b1},
    {32'h10008000, 32'h0,        1'b1, 1'b1},
    {32'h03E00008, 32'hFFFFFFFC, 1'b0, 1'b1},
    {32'h8C080000, 32'h0,        1'b0, 1'b1},
    {32'h0C000040, 32'h0,        1'b0, 1'b0}
  };

  function automatic logic [31:0] ref_next(input logic [31:0] pc, input logic [31:0] ins,
                                           input logic [31:0] rs, input logic eq);
    logic [31:0] s;
    s = pc + 32'd4;
    case (ins[31:26])
      6'd4: if (eq)  return s + {{14{ins[15]}}, ins[15:0], 2'b00};
      6'd5: if (!eq) return s + {{14{ins[15]}}, ins[15:0], 2'b00};
      6'd2, 6'd3: return {s[31:28], ins[25:0], 2'b00};
      6'd0: if (ins[5:0] == 6'h08 && rs[1:0] == 2'b00) return rs;
      default: ;
    endcase
    return s;
  endfunction

  function automatic string req_of(input logic [31:0] ins, input logic [31:0] rs, input logic en);
    if (!en) return "R2";
    case (ins[31:26])
      6'd4: return (ins[15:14] == 2'b01 || ins[15:14] == 2'b10) ? "R11" : "R4";
      6'd5: return "R5";
      6'd2: return "R6";
      6'd3: return "R7";
      6'd0: if (ins[5:0] != 6'h08) return "R10";
            else return (rs[1:0] != 0) ? "R9" : "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // called just after a falling edge
  task automatic apply(input logic [31:0] ins, input logic [31:0] rs, input logic eq, input logic en);
    string r;
    logic  jal, jr_bad;
    r = req_of(ins, rs, en);
    instr_i = ins; rs_val_i = rs; regs_eq_i = eq; en_i = en;
    #1;
    jal    = (ins[31:26] == 6'd3) && en;
    jr_bad = (ins[31:26] == 6'd0) && (ins[5:0] == 6'h08) && (rs[1:0] != 2'b00);
    check("R7", "link_we", {31'd0, link_we_o}, {31'd0, jal});
    if (jal) begin
      check("R7", "link_addr", {27'd0, link_addr_o}, 32'd31);
      check("R7", "link_data", link_data_o, pc_ref + 32'd4);
    end
    check("R9", "misalign", {31'd0, misalign_o}, {31'd0, jr_bad});
    if (en) pc_ref = ref_next(pc_ref, ins, rs, eq);
    @(negedge clk_i);
    check(r, "pc", pc_o, pc_ref);
  endtask

  initial begin
    #1;
    check("R1", "pc in reset", pc_o, 32'd0);
    check("R1", "link_we in reset", {31'd0, link_we_o}, 32'd0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++)
      apply(VECS[i][65:34], VECS[i][33:2], VECS[i][1], VECS[i][0]);
    // R3 wrap: top of address space steps to zero
    apply(32'h03E00008, 32'hFFFFFFFC, 1'b0, 1'b1);
    apply(32'h24000000, 32'h0, 1'b0, 1'b1);
    check("R3", "wrap to zero", pc_o, 32'd0);
    // R11 negative offset wrapping below zero
    apply(32'h10008000, 32'h0, 1'b1, 1'b1);
    // R7 link from a high jump region
    apply(32'h03E00008, 32'hA0000000, 1'b0, 1'b1);
    apply(32'h0C3FFFFF, 32'h0, 1'b0, 1'b1);
    // R1 asynchronous reset mid-run
    #1 rst_ni = 1'b0;
    #1 check("R1", "pc after async reset", pc_o, 32'd0);
    pc_ref = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    apply(32'h20080004, 32'h0, 1'b0, 1'b1);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule